// File: doc/BRIEF.md
# Queued Command Port Register Block

This block sits on the device side of a host register bus. The host posts 32-bit command addresses into a request queue by writing one register. It collects 32-bit completion words from a reply queue by reading another. A controller engine on the other side pops commands from the request queue and pushes completion words into the reply queue.

The host-visible encodings are inverted from the usual convention. The request port reads zero while there is room in the queue. The reply port reads all ones when the reply queue is empty. A reply entry leaves the queue only when the host writes zero back to the reply port. An interrupt output signals that completions are waiting, unless the host has set the disable bit in the mask register.

Register reads have no side effects. Both queues have a parameterised depth, which defaults to 8, and both report their occupancy to the controller.

Top module: `cmdq_regs`

## Requirements
- R1: After reset both queues are empty. The mask register reads 0x00000008, meaning the interrupt is disabled. The irq and overflow outputs are low.
- R2: A host write to offset 0x40 appends wdata to the request queue. req_valid is high while the queue holds entries, and req_data shows the oldest entry. Asserting req_pop while req_valid is high removes that entry, and entries leave in the order they were written.
- R3: A read of offset 0x40 returns 0x00000000 while the request queue holds fewer than DEPTH entries, and returns 0x00000001 when it is full.
- R4: A write to offset 0x40 while the request queue is full is dropped, even if req_pop is asserted in the same cycle. Such a write sets req_overflow, and req_overflow stays high until reset.
- R5: A read of offset 0x44 returns 0xFFFFFFFF when the reply queue is empty, and otherwise returns the oldest completion word. Reads never remove an entry.
- R6: A write of 0x00000000 to offset 0x44 removes the oldest reply entry. A nonzero write to 0x44 has no effect, and a zero write to an empty reply queue has no effect.
- R7: A write to offset 0x34 stores wdata bit 3 as the interrupt-disable bit. A read of 0x34 returns that bit in position 3, with all other bits zero.
- R8: A read of offset 0x30 returns bit 0 set while the reply queue is not empty, with all other bits zero.
- R9: irq is high exactly when the reply queue is not empty and the disable bit is clear.
- R10: req_count and rsp_count show the number of entries held in each queue. rsp_full is high when the reply queue holds DEPTH entries. An rsp_push while rsp_full is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Host byte address (word aligned) |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data for addr (combinational) |
| req_valid | output | 1 | Request queue not empty |
| req_data | output | 32 | Oldest command address |
| req_pop | input | 1 | Controller removes oldest command |
| req_count | output | CW | Request queue occupancy |
| req_overflow | output | 1 | Sticky: a host push was dropped |
| rsp_push | input | 1 | Controller appends a completion word |
| rsp_data | input | 32 | Completion word to append |
| rsp_full | output | 1 | Reply queue full |
| rsp_count | output | CW | Reply queue occupancy |
| irq | output | 1 | Interrupt to host |

## Verification
A pointer or counter that drifts inside this block shows up at once as a wrong count on req_count or rsp_count. It also shows up a cycle later as a word out of order, either on req_data or in the reply-port read. The empty and full encodings seen through rdata depend on the same counters, so a slip there corrupts the host view in the very cycle it happens. A wrongly sequenced acknowledge, such as a pop on a read or a pop on a nonzero write, changes rsp_count and the status bit on the next clock edge. A reference model of both queues runs beside the design and is compared every cycle, so each such error is caught within one cycle.

// File: rtl/cmdq_regs.sv
module cmdq_regs #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              req_valid,
  output logic [31:0]       req_data,
  input  logic              req_pop,
  output logic [CW-1:0]     req_count,
  output logic              req_overflow,
  input  logic              rsp_push,
  input  logic [31:0]       rsp_data,
  output logic              rsp_full,
  output logic [CW-1:0]     rsp_count,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_RSP  = ADDR_W'('h44);
  localparam logic [CW-1:0]     FULL_N = CW'(DEPTH);
  localparam logic [AW-1:0]     LAST   = AW'(DEPTH - 1);

  logic [31:0] req_mem [DEPTH];
  logic [31:0] rsp_mem [DEPTH];
  logic [AW-1:0] req_wp, req_rp, rsp_wp, rsp_rp;
  logic [CW-1:0] req_cnt, rsp_cnt;
  logic mask_off, ovf;

  wire sel_stat = addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2];
  wire sel_mask = addr[ADDR_W-1:2] == A_MASK[ADDR_W-1:2];
  wire sel_req  = addr[ADDR_W-1:2] == A_REQ[ADDR_W-1:2];
  wire sel_rsp  = addr[ADDR_W-1:2] == A_RSP[ADDR_W-1:2];

  wire req_full  = req_cnt == FULL_N;
  wire rsp_empty = rsp_cnt == '0;
  wire host_push = wr_en && sel_req;
  wire req_in    = host_push && !req_full;
  wire req_out   = req_pop && req_cnt != '0;
  wire ack_wr    = wr_en && sel_rsp && wdata == 32'h0;
  wire rsp_out   = ack_wr && !rsp_empty;
  wire rsp_in    = rsp_push && rsp_cnt != FULL_N;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_wp <= '0; req_rp <= '0; req_cnt <= '0;
      rsp_wp <= '0; rsp_rp <= '0; rsp_cnt <= '0;
      mask_off <= 1'b1;
      ovf <= 1'b0;
    end else begin
      if (req_in) begin
        req_mem[req_wp] <= wdata;
        req_wp <= nxt(req_wp);
      end
      if (req_out) req_rp <= nxt(req_rp);
      req_cnt <= req_cnt + CW'(req_in) - CW'(req_out);
      if (host_push && req_full) ovf <= 1'b1;
      if (rsp_in) begin
        rsp_mem[rsp_wp] <= rsp_data;
        rsp_wp <= nxt(rsp_wp);
      end
      if (rsp_out) rsp_rp <= nxt(rsp_rp);
      rsp_cnt <= rsp_cnt + CW'(rsp_in) - CW'(rsp_out);
      if (wr_en && sel_mask) mask_off <= wdata[3];
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (sel_req)       rdata = {31'h0, req_full};
    else if (sel_rsp)  rdata = rsp_empty ? 32'hFFFF_FFFF : rsp_mem[rsp_rp];
    else if (sel_mask) rdata = {28'h0, mask_off, 3'b000};
    else if (sel_stat) rdata = {31'h0, !rsp_empty};
  end

  assign req_valid    = req_cnt != '0;
  assign req_data     = req_mem[req_rp];
  assign req_count    = req_cnt;
  assign req_overflow = ovf;
  assign rsp_full     = rsp_cnt == FULL_N;
  assign rsp_count    = rsp_cnt;
  assign irq          = !rsp_empty && !mask_off;

  assert_req_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= FULL_N && rsp_cnt <= FULL_N);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && req_full && !req_pop) |=> req_cnt == FULL_N);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && !rsp_push) |=> $stable(rsp_cnt));
  assert_ack_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && rsp_empty && !rsp_push) |=> rsp_cnt == '0);
  assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_mask && wdata[3]) |=> !irq);
endmodule

// File: tb/test_cmdq_regs.sv
`timescale 1ns/100ps
module test_cmdq_regs;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, req_pop = 0, rsp_push = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rsp_data = 0, rdata, req_data;
  logic req_valid, req_overflow, rsp_full, irq;
  logic [CW-1:0] req_count, rsp_count;

  cmdq_regs #(.DEPTH(DEPTH), .ADDR_W(8)) i_cmdq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_valid(req_valid), .req_data(req_data),
    .req_pop(req_pop), .req_count(req_count), .req_overflow(req_overflow),
    .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_full(rsp_full),
    .rsp_count(rsp_count), .irq(irq));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int unsigned mq_req[$];
  int unsigned mq_rsp[$];
  bit m_mask = 1, m_ovf = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rsp_port();
    return (mq_rsp.size() == 0) ? 32'hFFFF_FFFF : mq_rsp[0];
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.2; d = rdata;
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(8'h40, d); chk(d, (mq_req.size() == DEPTH) ? 32'h1 : 32'h0, "R3 req port");
    rd(8'h44, d); chk(d, exp_rsp_port(), "R5 rsp port");
    rd(8'h34, d); chk(d, {28'h0, m_mask, 3'b0}, "R7 mask");
    rd(8'h30, d); chk(d, {31'h0, mq_rsp.size() != 0}, "R8 status");
    chk(32'(req_count), mq_req.size(), "R10 req_count");
    chk(32'(rsp_count), mq_rsp.size(), "R10 rsp_count");
    chk(32'(rsp_full), 32'(mq_rsp.size() == DEPTH), "R10 rsp_full");
    chk(32'(irq), 32'(mq_rsp.size() != 0 && !m_mask), "R9 irq");
    chk(32'(req_overflow), 32'(m_ovf), "R4 overflow");
    chk(32'(req_valid), 32'(mq_req.size() != 0), "R2 req_valid");
    if (mq_req.size() != 0) chk(req_data, mq_req[0], "R2 req_data");
  endtask

  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit pop, input bit push, input logic [31:0] pd);
    bit rq_full, rs_full;
    wr_en = w; addr = a; wdata = d; req_pop = pop; rsp_push = push; rsp_data = pd;
    @(posedge clk);
    rq_full = mq_req.size() == DEPTH;
    rs_full = mq_rsp.size() == DEPTH;
    if (pop && mq_req.size() != 0) void'(mq_req.pop_front());
    if (w && a == 8'h40) begin
      if (rq_full) m_ovf = 1; else mq_req.push_back(d);
    end
    if (w && a == 8'h44 && d == 0 && mq_rsp.size() != 0) void'(mq_rsp.pop_front());
    if (push && !rs_full) mq_rsp.push_back(pd);
    if (w && a == 8'h34) m_mask = d[3];
    @(negedge clk);
    wr_en = 0; req_pop = 0; rsp_push = 0;
    check_all();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd(8'h34, d); chk(d, 32'h8, "R1 mask reset");
    chk(32'(req_count), 0, "R1 req empty");
    chk(32'(rsp_count), 0, "R1 rsp empty");
    chk(32'(irq), 0, "R1 irq low");
    chk(32'(req_overflow), 0, "R1 overflow low");
    rd(8'h44, d); chk(d, 32'hFFFF_FFFF, "R1 rsp port empty");
    check_all();

    // R2/R3/R4: fill the request queue, then overrun it
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'h40, 32'hA000_0000 + i, 0, 0, 0);
    rd(8'h40, d); chk(d, 32'h1, "R3 full reads one");
    cyc(1, 8'h40, 32'hDEAD_0001, 1, 0, 0);
    chk(32'(req_overflow), 1, "R4 overflow set");
    chk(32'(req_count), DEPTH - 1, "R4 push with pop at full dropped");
    for (int i = 1; i < DEPTH; i++) begin
      chk(req_data, 32'hA000_0000 + i, "R2 fifo order");
      cyc(0, 8'h00, 0, 1, 0, 0);
    end
    chk(32'(req_valid), 0, "R2 drained");
    chk(32'(req_overflow), 1, "R4 overflow sticky");

    // R5/R6/R8/R9: reply queue handshake
    cyc(1, 8'h44, 0, 0, 0, 0);
    chk(32'(rsp_count), 0, "R6 ack on empty ignored");
    cyc(1, 8'h34, 0, 0, 1, 32'h1111_0001);
    chk(32'(irq), 1, "R9 irq enabled and pending");
    cyc(0, 8'h00, 0, 0, 1, 32'h1111_0002);
    rd(8'h44, d); chk(d, 32'h1111_0001, "R5 oldest word");
    rd(8'h44, d); chk(d, 32'h1111_0001, "R5 reread same word");
    cyc(1, 8'h44, 32'h5, 0, 0, 0);
    chk(32'(rsp_count), 2, "R6 nonzero write ignored");
    cyc(1, 8'h44, 0, 0, 0, 0);
    rd(8'h44, d); chk(d, 32'h1111_0002, "R6 ack pops");
    cyc(1, 8'h34, 32'hFFFF_FFFF, 0, 0, 0);
    chk(32'(irq), 0, "R9 masked");
    rd(8'h30, d); chk(d, 32'h1, "R8 pending while masked");
    cyc(1, 8'h44, 0, 0, 0, 0);
    rd(8'h30, d); chk(d, 32'h0, "R8 cleared");

    // R10: overfill the reply queue
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 8'h00, 0, 0, 1, 32'hC000_0000 + i);
    chk(32'(rsp_full), 1, "R10 rsp_full");
    rd(8'h44, d); chk(d, 32'hC000_0000, "R10 overfill kept oldest");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned op = $urandom % 8;
      bit pop = ($urandom % 3) == 0;
      bit push = ($urandom % 2) == 0;
      logic [31:0] pd = $urandom;
      case (op)
        0, 1, 2: cyc(1, 8'h40, $urandom, pop, push, pd);
        3, 4:    cyc(1, 8'h44, 0, pop, push, pd);
        5:       cyc(1, 8'h44, $urandom | 32'h1, pop, push, pd);
        6:       cyc(1, 8'h34, $urandom, pop, push, pd);
        default: cyc(0, 8'h00, 0, pop, push, pd);
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule